// File: doc/BRIEF.md
# Nestable Priority Interrupt Controller

This block chooses which interrupt an 8-bit microcontroller core takes next. Fifteen edge-triggered hardware sources and one software break request compete for service. A source is a candidate only when three things hold: its pending latch is set, its own bit in the two 8-bit enable registers is set, and the master interrupt-enable flag is set. The software break is the exception, because it needs only its pending latch. Among the candidates, a fixed order decides the winner. The higher source index wins, and the break comes last. The chosen index goes to the core with a one-cycle acknowledge pulse.

Each acceptance pushes the current status pair (master enable and break flag) onto a small internal stack. It then clears the master enable. It sets the break flag for a break and clears it for a hardware source, which lets the core separate a break from a table call 0 that uses the same vector. The core reports its own instruction events as strobes: enable interrupts, disable interrupts, return from interrupt, table call 0, break, and the two enable-register writes. A service routine that re-enables the master flag can therefore be interrupted by another enabled source, and each return from interrupt restores the saved pair.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, both enable registers, the master enable flag, the break flag and the overflow flag are 0, no acknowledge is given and nothing is pending.
- R2: Hardware source n has vector n (1 to 15). Among eligible sources the highest n is acknowledged first. The break request has vector 0 and is acknowledged only after every eligible hardware source in the same cycle.
- R3: Hardware source n is eligible only if its latch is pending, bit n of {high register, low register} is 1, and the master enable flag is 1. For example, source 11 is enabled by bit 3 of the high register (value 08h). The break request is accepted even when the master enable flag is 0.
- R4: A request line that stays high raises only one pending event. A second acknowledge needs a new rising edge.
- R5: An acknowledge is a single-cycle pulse that carries the vector. The acknowledged source's pending latch is cleared, so each request event gets exactly one acknowledge.
- R6: On acceptance, the master enable flag becomes 0. The break flag becomes 1 for a break and 0 for a hardware source.
- R7: The enable-interrupts strobe sets the master enable flag inside a service routine, and this lets a pending enabled source be accepted on top of the running one.
- R8: The return strobe pops the status stack and restores both flags. On an empty stack it changes neither flag.
- R9: The status stack holds 4 entries. An acceptance while it is full drops the push and sets a sticky overflow flag that only reset clears.
- R10: The table-call-0 strobe clears the break flag and produces no acknowledge.
- R11: No acceptance happens in a cycle with a core strobe (enable or disable interrupts, return, table call 0, enable-register write). A request that was eligible in that cycle is acknowledged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 15 | Hardware request lines, indices 15 down to 1 |
| brkStb | input | 1 | Software break executed |
| tcallStb | input | 1 | Table call 0 executed |
| eiStb | input | 1 | Enable-interrupts instruction |
| diStb | input | 1 | Disable-interrupts instruction |
| retiStb | input | 1 | Return-from-interrupt instruction |
| enWrHi | input | 1 | Write enWrData into the high enable register |
| enWrLo | input | 1 | Write enWrData into the low enable register |
| enWrData | input | 8 | Enable register write data |
| ackPulse | output | 1 | One-cycle acknowledge |
| ackVec | output | 4 | Vector of the acknowledged request |
| enHi | output | 8 | High enable register (sources 15 to 8) |
| enLo | output | 8 | Low enable register (sources 7 to 1, bit 0 stored only) |
| iFlag | output | 1 | Master interrupt enable |
| bFlag | output | 1 | Break flag |
| stackOvf | output | 1 | Sticky status stack overflow |

## Verification
The hardest state to reach is a full status stack with the break flag saved as 1 underneath a hardware entry. Getting there needs a chain of acceptances, and each one has to be re-armed by an enable-interrupts strobe, because acceptance itself clears the master flag. The stimulus fills the stack with three requests that arrive together and are served in priority order. A break then overflows the stack. Next a break is nested under a hardware source and both levels are unwound, so that both saved pairs are checked on return. Back-to-back acknowledges, for a hardware source followed by a break that ignores the cleared master flag, are also driven.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic accept;   // an interrupt is taken this cycle
    logic isBrk;    // the taken interrupt is the software break
    logic setI;     // enable-interrupts instruction
    logic clrI;     // disable-interrupts instruction
    logic pop;      // return from interrupt
    logic clrB;     // table call 0
    logic wrHi;     // high enable register write
    logic wrLo;     // low enable register write
  } ctl_stb_t;

  // Status pair saved on entry
  typedef struct packed {
    logic iFlag;
    logic bFlag;
  } status_t;

endpackage

// File: rtl/irq_nest_control.sv
module irq_nest_control
  import irq_nest_pkg::*;
#(
  parameter int EN_W = 8,
  localparam int NUM_SRC = 2 * EN_W,
  localparam int VEC_W = $clog2(2 * EN_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:1]   irqReq,
  input  logic                 brkStb,
  input  logic                 tcallStb,
  input  logic                 eiStb,
  input  logic                 diStb,
  input  logic                 retiStb,
  input  logic                 enWrHi,
  input  logic                 enWrLo,
  input  logic [NUM_SRC-1:1]   enVec,
  input  logic                 iFlag,
  output ctl_stb_t             stb,
  output logic                 ackPulse,
  output logic [VEC_W-1:0]     ackVec
);

  logic [NUM_SRC-1:1] reqPrev;
  logic [NUM_SRC-1:1] hwPend;
  logic               brkPend;
  logic [NUM_SRC-1:1] elig;
  logic [NUM_SRC-1:1] clrMask;
  logic [VEC_W-1:0]   winVec;
  logic               winHit;
  logic               coreBusy;
  logic               acceptNow;
  logic               takeBrk;

  // Fixed polling order: later (higher) index overrides earlier
  always_comb begin
    elig   = hwPend & enVec & {(NUM_SRC-1){iFlag}};
    winVec = '0;
    winHit = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (elig[i]) begin
        winVec = VEC_W'(i);
        winHit = 1'b1;
      end
    end
  end

  assign coreBusy  = eiStb | diStb | retiStb | tcallStb | enWrHi | enWrLo;
  assign acceptNow = !coreBusy && (winHit || brkPend);
  assign takeBrk   = acceptNow && !winHit;

  always_comb begin
    for (int i = 1; i < NUM_SRC; i++) begin
      clrMask[i] = acceptNow && winHit && (winVec == VEC_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev  <= '0;
      hwPend   <= '0;
      brkPend  <= 1'b0;
      ackPulse <= 1'b0;
      ackVec   <= '0;
    end else begin
      reqPrev  <= irqReq;
      hwPend   <= (hwPend & ~clrMask) | (irqReq & ~reqPrev);
      brkPend  <= (brkPend & ~takeBrk) | brkStb;
      ackPulse <= acceptNow;
      ackVec   <= takeBrk ? '0 : winVec;
    end
  end

  always_comb begin
    stb.accept = acceptNow;
    stb.isBrk  = takeBrk;
    stb.setI   = eiStb;
    stb.clrI   = diStb;
    stb.pop    = retiStb;
    stb.clrB   = tcallStb;
    stb.wrHi   = enWrHi;
    stb.wrLo   = enWrLo;
  end

  // R3: a hardware vector is only granted while the master flag was set
  a_r3_hw_needs_i: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && ackVec != '0) |-> $past(iFlag));

  // R2: the break vector is granted only when no hardware source was eligible
  a_r2_brk_lowest: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && ackVec == '0) |-> ($past(elig) == '0));

  // R11: a core strobe never coincides with the datapath seeing an accept
  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (eiStb || diStb || retiStb || tcallStb || enWrHi || enWrLo) |=> !ackPulse);

endmodule

// File: rtl/irq_nest_datapath.sv
module irq_nest_datapath
  import irq_nest_pkg::*;
#(
  parameter int EN_W = 8,
  parameter int STACK_DEPTH = 4,
  localparam int SP_W = $clog2(STACK_DEPTH + 1),
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_stb_t        stb,
  input  logic [EN_W-1:0] wrData,
  output logic [EN_W-1:0] enHi,
  output logic [EN_W-1:0] enLo,
  output logic            iFlag,
  output logic            bFlag,
  output logic            stackOvf
);

  status_t          stackMem [STACK_DEPTH];
  logic [SP_W-1:0]  sp;
  logic             stackFull;
  logic             stackEmpty;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] topIdx;

  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign stackEmpty = (sp == '0);
  assign wrIdx      = IDX_W'(sp);
  assign topIdx     = IDX_W'(sp - 1'b1);

  always_ff @(posedge clk) begin
    if (stb.accept && !stackFull) begin
      stackMem[wrIdx] <= '{iFlag: iFlag, bFlag: bFlag};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enHi     <= '0;
      enLo     <= '0;
      iFlag    <= 1'b0;
      bFlag    <= 1'b0;
      stackOvf <= 1'b0;
      sp       <= '0;
    end else begin
      if (stb.wrHi) enHi <= wrData;
      if (stb.wrLo) enLo <= wrData;
      if (stb.accept) begin
        if (stackFull) stackOvf <= 1'b1;
        else           sp <= sp + 1'b1;
        iFlag <= 1'b0;
        bFlag <= stb.isBrk;
      end else if (stb.pop) begin
        if (!stackEmpty) begin
          iFlag <= stackMem[topIdx].iFlag;
          bFlag <= stackMem[topIdx].bFlag;
          sp    <= sp - 1'b1;
        end
      end else begin
        if (stb.setI)      iFlag <= 1'b1;
        else if (stb.clrI) iFlag <= 1'b0;
        if (stb.clrB)      bFlag <= 1'b0;
      end
    end
  end

  // R6: acceptance leaves the master flag clear
  a_r6_accept_clears_i: assert property (@(posedge clk) disable iff (!rstN)
    stb.accept |=> !iFlag);

  // R6: break acceptance sets the break flag
  a_r6_brk_sets_b: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && stb.isBrk) |=> bFlag);

  // R9: overflow is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    stackOvf |=> stackOvf);

  // R9: the pointer never passes the depth
  a_r9_sp_bound: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(STACK_DEPTH));

  // R8: a pop on an empty stack leaves both flags unchanged
  a_r8_empty_pop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && !stb.accept && stackEmpty) |=> (iFlag == $past(iFlag) && bFlag == $past(bFlag)));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int EN_W = 8,
  parameter int STACK_DEPTH = 4,
  localparam int NUM_SRC = 2 * EN_W,
  localparam int VEC_W = $clog2(2 * EN_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:1] irqReq,
  input  logic               brkStb,
  input  logic               tcallStb,
  input  logic               eiStb,
  input  logic               diStb,
  input  logic               retiStb,
  input  logic               enWrHi,
  input  logic               enWrLo,
  input  logic [EN_W-1:0]    enWrData,
  output logic               ackPulse,
  output logic [VEC_W-1:0]   ackVec,
  output logic [EN_W-1:0]    enHi,
  output logic [EN_W-1:0]    enLo,
  output logic               iFlag,
  output logic               bFlag,
  output logic               stackOvf
);

  ctl_stb_t             stb;
  logic [NUM_SRC-1:0]   enAll;

  assign enAll = {enHi, enLo};

  irq_nest_control #(.EN_W(EN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .brkStb   (brkStb),
    .tcallStb (tcallStb),
    .eiStb    (eiStb),
    .diStb    (diStb),
    .retiStb  (retiStb),
    .enWrHi   (enWrHi),
    .enWrLo   (enWrLo),
    .enVec    (enAll[NUM_SRC-1:1]),
    .iFlag    (iFlag),
    .stb      (stb),
    .ackPulse (ackPulse),
    .ackVec   (ackVec)
  );

  irq_nest_datapath #(.EN_W(EN_W), .STACK_DEPTH(STACK_DEPTH)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (enWrData),
    .enHi     (enHi),
    .enLo     (enLo),
    .iFlag    (iFlag),
    .bFlag    (bFlag),
    .stackOvf (stackOvf)
  );

endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;

  localparam int OP_EI = 0, OP_DI = 1, OP_RETI = 2, OP_TCALL = 3,
                 OP_BRK = 4, OP_WRHI = 5, OP_WRLO = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:1] irqReq = '0;
  logic        brkStb = 1'b0, tcallStb = 1'b0, eiStb = 1'b0, diStb = 1'b0, retiStb = 1'b0;
  logic        enWrHi = 1'b0, enWrLo = 1'b0;
  logic [7:0]  enWrData = '0;
  logic        ackPulse;
  logic [3:0]  ackVec;
  logic [7:0]  enHi, enLo;
  logic        iFlag, bFlag, stackOvf;

  int checks = 0;
  int fails = 0;
  int expQ[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .brkStb(brkStb), .tcallStb(tcallStb),
    .eiStb(eiStb), .diStb(diStb), .retiStb(retiStb), .enWrHi(enWrHi), .enWrLo(enWrLo),
    .enWrData(enWrData), .ackPulse(ackPulse), .ackVec(ackVec), .enHi(enHi), .enLo(enLo),
    .iFlag(iFlag), .bFlag(bFlag), .stackOvf(stackOvf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectAck(input int v);
    expQ.push_back(v);
  endtask

  task automatic strobe(input int op, input logic [7:0] d);
    case (op)
      OP_EI:    eiStb = 1'b1;
      OP_DI:    diStb = 1'b1;
      OP_RETI:  retiStb = 1'b1;
      OP_TCALL: tcallStb = 1'b1;
      OP_BRK:   brkStb = 1'b1;
      OP_WRHI:  begin enWrHi = 1'b1; enWrData = d; end
      default:  begin enWrLo = 1'b1; enWrData = d; end
    endcase
    tick(1);
    {eiStb, diStb, retiStb, tcallStb, brkStb, enWrHi, enWrLo} = '0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: compares every acknowledge against the scoreboard queue (R5)
  always @(negedge clk) begin
    int e;
    if (rstN && ackPulse) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R5 unexpected acknowledge", int'(ackVec), -1);
      end else begin
        e = expQ.pop_front();
        chk(int'(ackVec) == e, "R2/R5 acknowledge vector", int'(ackVec), e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk(enHi == 8'h00, "R1 enHi", enHi, 0);
    chk(enLo == 8'h00, "R1 enLo", enLo, 0);
    chk(iFlag == 1'b0, "R1 iFlag", iFlag, 0);
    chk(bFlag == 1'b0, "R1 bFlag", bFlag, 0);
    chk(stackOvf == 1'b0, "R1 stackOvf", stackOvf, 0);
    chk(ackPulse == 1'b0, "R1 ackPulse", ackPulse, 0);

    strobe(OP_WRHI, 8'hFF);
    strobe(OP_WRLO, 8'hFF);
    chk(enHi == 8'hFF, "R3 enable write", enHi, 8'hFF);

    // R3: source 11 (high bit 3) pending but master flag clear
    irqReq[11] = 1'b1;
    tick(4);
    chk(iFlag == 1'b0, "R3 no accept while master flag clear", iFlag, 0);
    expectAck(11);
    strobe(OP_EI, 8'h00);
    tick(2);
    chk(iFlag == 1'b0, "R6 master flag cleared on accept", iFlag, 0);
    chk(bFlag == 1'b0, "R6 break flag clear for hardware", bFlag, 0);

    // R4: held line gives no second event
    strobe(OP_EI, 8'h00);
    tick(4);
    chk(iFlag == 1'b1, "R4 held request not re-accepted", iFlag, 1);
    irqReq[11] = 1'b0;

    // R2 / R7: simultaneous requests served highest first, nesting via EI
    irqReq[3] = 1'b1; irqReq[9] = 1'b1; irqReq[14] = 1'b1;
    expectAck(14);
    tick(3);
    expectAck(9);
    strobe(OP_EI, 8'h00);
    tick(2);
    expectAck(3);
    strobe(OP_EI, 8'h00);
    tick(2);
    irqReq = '0;
    chk(iFlag == 1'b0, "R7 nested accept cleared master flag", iFlag, 0);

    // R3 / R9: break with master flag clear overflows the full stack
    expectAck(0);
    strobe(OP_BRK, 8'h00);
    tick(2);
    chk(bFlag == 1'b1, "R6 break flag set", bFlag, 1);
    chk(stackOvf == 1'b1, "R9 overflow on full push", stackOvf, 1);

    // R8: pops restore the saved pair
    strobe(OP_RETI, 8'h00);
    tick(1);
    chk(iFlag == 1'b1, "R8 restored master flag", iFlag, 1);
    chk(bFlag == 1'b0, "R8 restored break flag", bFlag, 0);
    strobe(OP_RETI, 8'h00);
    strobe(OP_RETI, 8'h00);
    strobe(OP_RETI, 8'h00);
    strobe(OP_DI, 8'h00);
    strobe(OP_RETI, 8'h00);
    tick(1);
    chk(iFlag == 1'b0, "R8 empty pop keeps master flag", iFlag, 0);
    chk(stackOvf == 1'b1, "R9 overflow sticky", stackOvf, 1);

    // R8: break saved under a hardware entry
    expectAck(0);
    strobe(OP_BRK, 8'h00);
    tick(2);
    strobe(OP_EI, 8'h00);
    irqReq[5] = 1'b1;
    expectAck(5);
    tick(3);
    irqReq[5] = 1'b0;
    chk(bFlag == 1'b0, "R6 hardware accept clears break flag", bFlag, 0);
    strobe(OP_RETI, 8'h00);
    tick(1);
    chk(iFlag == 1'b1 && bFlag == 1'b1, "R8 inner pop restores I=1 B=1",
        {iFlag, bFlag}, 3);
    strobe(OP_RETI, 8'h00);
    tick(1);
    chk(iFlag == 1'b0 && bFlag == 1'b0, "R8 outer pop restores I=0 B=0",
        {iFlag, bFlag}, 0);

    // R10: table call clears break flag, no acknowledge
    expectAck(0);
    strobe(OP_BRK, 8'h00);
    tick(2);
    strobe(OP_TCALL, 8'h00);
    tick(2);
    chk(bFlag == 1'b0, "R10 table call clears break flag", bFlag, 0);
    strobe(OP_RETI, 8'h00);

    // R2: hardware and break together, break served last
    strobe(OP_EI, 8'h00);
    irqReq[2] = 1'b1;
    brkStb = 1'b1;
    expectAck(2);
    expectAck(0);
    tick(1);
    brkStb = 1'b0;
    tick(3);
    irqReq[2] = 1'b0;
    chk(bFlag == 1'b1, "R2 break taken after hardware", bFlag, 1);

    // R11: register write blocks acceptance for one cycle
    strobe(OP_EI, 8'h00);
    irqReq[7] = 1'b1;
    tick(1);
    enWrLo = 1'b1; enWrData = 8'hFF;
    tick(1);
    chk(ackPulse == 1'b0, "R11 no accept during core strobe", ackPulse, 0);
    enWrLo = 1'b0;
    expectAck(7);
    tick(2);
    irqReq[7] = 1'b0;

    // R3: cleared enable bit blocks source 6
    strobe(OP_EI, 8'h00);
    strobe(OP_WRLO, 8'hBF);
    irqReq[6] = 1'b1;
    tick(4);
    chk(iFlag == 1'b1, "R3 disabled source not accepted", iFlag, 1);
    expectAck(6);
    strobe(OP_WRLO, 8'hFF);
    tick(2);
    irqReq[6] = 1'b0;

    tick(2);
    chk(expQ.size() == 0, "R5 every expected acknowledge seen", expQ.size(), 0);
    finishRun();
  end

endmodule